// File: doc/BRIEF.md
# LIN Break-Field Detecting Receiver

This block is the receive front-end of a LIN-capable asynchronous serial port. It watches the serial input for a break field, which is a long dominant low on the line. It measures how long the low lasts in 16x-oversampled ticks and accepts it as a break only if it lasts at least 11 bit times. When software arms break reception, the block enters a break-wait state. In that state the minimal 8N1 byte receiver is held idle, so no error flag can be raised and the data register is never overwritten. A valid break ends the wait, sets a success flag, pulses the status interrupt and hands the line back to byte reception.

The link controller is a three-state machine:
- `LNK_OFF`: the receiver is disabled.
- `LNK_RUN`: normal byte reception.
- `LNK_BRK`: break wait and measurement.

It has these transitions:
- `arm`: any state to `LNK_BRK` on the trigger while enabled.
- `enable`: `LNK_OFF` to `LNK_RUN`.
- `brk_valid`: `LNK_BRK` to `LNK_RUN` on a long enough low.
- `auto_rearm`: `LNK_RUN` to `LNK_BRK` on an all-zero byte with a low stop bit in auto mode.
- `disable`: any state to `LNK_OFF`.

The byte receiver has four states: `BR_IDLE`, `BR_START`, `BR_DATA` and `BR_STOP`. It leaves `BR_IDLE` on a falling edge. It confirms the start bit at half a bit time, samples each data bit every bit time, and samples the stop bit last.

In the auto mode (`mode` = 2'b10), a break that arrives during communication is picked up without software. Such a break first shows up as a zero byte with a low stop bit. That byte is discarded, and the block drops back into the break-wait state while the low is still being timed.

Top module: `lin_brk_rx`

## Requirements
- R1: A low on the synchronized line lasting at least 176 `os_tick` periods (11 bit times), ended by a rising edge while in break wait, sets `brk_ok`, clears `brk_busy`, and gives exactly one cycle of `irq_stat`. A low of exactly 176 ticks is accepted.
- R2: A nominal 13-bit break (208 ticks) is accepted in the same way as R1.
- R3: A low of 175 ticks or fewer, ended in break wait, raises no `irq_stat`, leaves `brk_ok` unchanged and keeps `brk_busy` at 1.
- R4: A `brk_arm` pulse with `rx_en` high sets `brk_busy` on the next cycle. With `rx_en` low, the pulse has no effect.
- R5: While `brk_busy` is 1, `rx_data` holds its value, no `irq_rx` occurs, and `fe_flag` and `ove_flag` do not become set.
- R6: In normal reception, each 8N1 byte (start bit low, 8 data bits LSB first, then stop bit) is written to `rx_data` together with a one-cycle `irq_rx`.
- R7: In normal reception, a byte whose stop bit samples low sets `fe_flag`. The byte is still delivered.
- R8: A byte that completes while the previous byte is still unread sets `ove_flag`. A `data_read` pulse marks the current byte as read.
- R9: With `mode` = 2'b10, a low of 11 or more bits during normal reception sets `brk_busy` again without `brk_arm`. It ends as a valid break with no `irq_rx` and no `fe_flag`. With any other mode, the same low is delivered as byte 0x00 with `fe_flag` set.
- R10: Reset clears every flag and `rx_data`. Writing 1 to `clr_flags` bit 0, bit 1 or bit 2 clears `brk_ok`, `fe_flag` or `ove_flag` respectively.
- R11: With `rx_en` low, `brk_busy` is 0 and no byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, asynchronous |
| os_tick | input | 1 | 16x oversampling tick |
| rx_en | input | 1 | Receiver enable |
| mode | input | 2 | Operating mode; 2'b10 enables automatic break re-arm |
| brk_arm | input | 1 | Strobe that arms break reception |
| data_read | input | 1 | Strobe marking `rx_data` as consumed |
| clr_flags | input | 3 | Write-one-to-clear: bit0 brk_ok, bit1 fe_flag, bit2 ove_flag |
| brk_busy | output | 1 | Break reception in progress |
| brk_ok | output | 1 | Valid break received |
| fe_flag | output | 1 | Framing error |
| ove_flag | output | 1 | Overrun error |
| rx_data | output | 8 | Last received byte |
| irq_stat | output | 1 | Status interrupt pulse on a valid break |
| irq_rx | output | 1 | Reception interrupt pulse per delivered byte |

## Verification
The break-length counter and the link state machine can each go wrong in ways that show at the ports.

A wrong break-length counter shows up at the rising edge that ends the low. It appears about three cycles after the line returns high, either as a missing `irq_stat` pulse or as one that should not be there. The 175-tick and 176-tick lows pin down the threshold exactly.

A link state machine stuck in the wrong state shows one cycle after the causing event, as a wrong `brk_busy` level. Later, a byte is delivered or withheld against expectation, which the scoreboard reports at the next `irq_rx`.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    // Link-level controller states
    typedef enum logic [1:0] {
        LNK_OFF = 2'd0,
        LNK_RUN = 2'd1,
        LNK_BRK = 2'd2
    } lnk_state_t;

    // Byte receiver states
    typedef enum logic [1:0] {
        BR_IDLE  = 2'd0,
        BR_START = 2'd1,
        BR_DATA  = 2'd2,
        BR_STOP  = 2'd3
    } byte_state_t;

    // Mode encoding that re-arms break detection during communication
    localparam logic [1:0] MODE_AUTO_BRK = 2'b10;

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '1;
            line_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], rxd};
            line_q <= chain[STAGES-1];
        end
    end

    assign line = chain[STAGES-1];
    assign rise = line & ~line_q;
    assign fall = ~line & line_q;
endmodule

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
    parameter int OSR      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic rise,
    input  logic os_tick,
    output logic long_low_end
);
    localparam int THRESH = OSR * BRK_BITS;
    localparam int CNT_W  = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

    logic [CNT_W-1:0] low_cnt;

    // Counts ticks of a continuous low, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (line) begin
            low_cnt <= '0;
        end else if (os_tick && (low_cnt != THR_V)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign long_low_end = rise && (low_cnt == THR_V);
endmodule

// File: rtl/lin_byte_rx.sv
module lin_byte_rx
    import lin_brk_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             line,
    input  logic             fall,
    input  logic             os_tick,
    output logic             done,
    output logic [DBITS-1:0] data,
    output logic             stop_bit
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = (DBITS > 1) ? $clog2(DBITS) : 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] HALF_TICK = CNT_W'(OSR / 2 - 1);
    localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DBITS - 1);

    byte_state_t      st;
    logic [CNT_W-1:0] tcnt;
    logic [IDX_W-1:0] bidx;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st       <= BR_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            data     <= '0;
            stop_bit <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                BR_IDLE: begin
                    if (fall) begin
                        st   <= BR_START;
                        tcnt <= '0;
                    end
                end
                BR_START: begin
                    if (os_tick) begin
                        if (tcnt == HALF_TICK) begin
                            tcnt <= '0;
                            bidx <= '0;
                            st   <= line ? BR_IDLE : BR_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                BR_DATA: begin
                    if (os_tick) begin
                        if (tcnt == LAST_TICK) begin
                            tcnt <= '0;
                            data <= {line, data[DBITS-1:1]};
                            if (bidx == LAST_BIT) begin
                                st <= BR_STOP;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                BR_STOP: begin
                    if (os_tick) begin
                        if (tcnt == LAST_TICK) begin
                            tcnt     <= '0;
                            stop_bit <= line;
                            done     <= 1'b1;
                            st       <= BR_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: st <= BR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lin_brk_rx.sv
module lin_brk_rx
    import lin_brk_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int BRK_BITS    = 11,
    parameter int DBITS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             os_tick,
    input  logic             rx_en,
    input  logic [1:0]       mode,
    input  logic             brk_arm,
    input  logic             data_read,
    input  logic [2:0]       clr_flags,
    output logic             brk_busy,
    output logic             brk_ok,
    output logic             fe_flag,
    output logic             ove_flag,
    output logic [DBITS-1:0] rx_data,
    output logic             irq_stat,
    output logic             irq_rx
);
    logic             line, rise, fall;
    logic             long_low_end;
    logic             b_done, b_stop;
    logic [DBITS-1:0] b_data;
    logic             unread;

    lnk_state_t state, state_nx;

    lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .line(line), .rise(rise), .fall(fall)
    );

    lin_low_timer #(.OSR(OSR), .BRK_BITS(BRK_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .line(line), .rise(rise),
        .os_tick(os_tick), .long_low_end(long_low_end)
    );

    lin_byte_rx #(.OSR(OSR), .DBITS(DBITS)) u_byte (
        .clk(clk), .rst_n(rst_n), .en(state == LNK_RUN),
        .line(line), .fall(fall), .os_tick(os_tick),
        .done(b_done), .data(b_data), .stop_bit(b_stop)
    );

    // Event decode
    logic brk_valid, auto_rearm, load;
    assign brk_valid  = (state == LNK_BRK) && long_low_end && rx_en && !brk_arm;
    assign auto_rearm = (state == LNK_RUN) && (mode == MODE_AUTO_BRK) &&
                        b_done && (b_data == '0) && !b_stop;
    assign load       = (state == LNK_RUN) && b_done && !auto_rearm;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LNK_OFF;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (!rx_en) begin
            state_nx = LNK_OFF;
        end else if (brk_arm) begin
            state_nx = LNK_BRK;
        end else begin
            unique case (state)
                LNK_OFF: state_nx = LNK_RUN;
                LNK_RUN: if (auto_rearm) state_nx = LNK_BRK;
                LNK_BRK: if (brk_valid)  state_nx = LNK_RUN;
                default: state_nx = LNK_OFF;
            endcase
        end
    end

    // Outputs and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_ok   <= 1'b0;
            fe_flag  <= 1'b0;
            ove_flag <= 1'b0;
            rx_data  <= '0;
            irq_stat <= 1'b0;
            irq_rx   <= 1'b0;
            unread   <= 1'b0;
        end else begin
            irq_stat <= brk_valid;
            irq_rx   <= load;

            if (brk_valid)         brk_ok <= 1'b1;
            else if (clr_flags[0]) brk_ok <= 1'b0;

            if (load && !b_stop)   fe_flag <= 1'b1;
            else if (clr_flags[1]) fe_flag <= 1'b0;

            if (load && unread && !data_read) ove_flag <= 1'b1;
            else if (clr_flags[2])            ove_flag <= 1'b0;

            if (load)           unread <= 1'b1;
            else if (data_read) unread <= 1'b0;

            if (load) rx_data <= b_data;
        end
    end

    assign brk_busy = (state == LNK_BRK);
endmodule

// File: rtl/lin_brk_rx_chk.sv
module lin_brk_rx_chk #(
    parameter int DBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             brk_arm,
    input logic             brk_busy,
    input logic             brk_ok,
    input logic             fe_flag,
    input logic             ove_flag,
    input logic [DBITS-1:0] rx_data,
    input logic             irq_stat,
    input logic             irq_rx
);
    AST_STAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat |=> !irq_stat); // R1
    AST_STAT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat |-> (brk_ok && !brk_busy)); // R1
    AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && brk_arm) |=> brk_busy); // R4
    AST_BUSY_NO_FE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_busy |=> !$rose(fe_flag)); // R5
    AST_BUSY_NO_OVE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_busy |=> !$rose(ove_flag)); // R5
    AST_BUSY_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        brk_busy |=> $stable(rx_data)); // R5
    AST_BUSY_NO_RXIRQ: assert property (@(posedge clk) disable iff (!rst_n)
        brk_busy |=> !irq_rx); // R5
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx); // R6
    AST_OFF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !brk_busy); // R11
endmodule

bind lin_brk_rx lin_brk_rx_chk #(.DBITS(DBITS)) u_chk (.*);

// File: tb/lin_brk_rx_bench.sv
module lin_brk_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       brk_arm = 1'b0;
    logic       data_read = 1'b0;
    logic [2:0] clr_flags = 3'b000;
    logic       brk_busy, brk_ok, fe_flag, ove_flag, irq_stat, irq_rx;
    logic [7:0] rx_data;

    int checks = 0;
    int failures = 0;
    int stat_cnt = 0;
    logic prev_stat = 1'b0;
    logic finished = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    lin_brk_rx u_lin_brk_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .rx_en(rx_en), .mode(mode), .brk_arm(brk_arm),
        .data_read(data_read), .clr_flags(clr_flags),
        .brk_busy(brk_busy), .brk_ok(brk_ok), .fe_flag(fe_flag),
        .ove_flag(ove_flag), .rx_data(rx_data),
        .irq_stat(irq_stat), .irq_rx(irq_rx)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic line_low(int n);
        rxd = 1'b0;
        hold(n);
        rxd = 1'b1;
        hold(40);
    endtask

    task automatic send_byte(logic [7:0] b, logic stop);
        rxd = 1'b0;
        hold(16);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            hold(16);
        end
        rxd = stop;
        hold(16);
        rxd = 1'b1;
        hold(32);
    endtask

    task automatic pulse_arm();
        brk_arm = 1'b1;
        hold(1);
        brk_arm = 1'b0;
    endtask

    task automatic pulse_read();
        data_read = 1'b1;
        hold(1);
        data_read = 1'b0;
    endtask

    task automatic clear(logic [2:0] m);
        clr_flags = m;
        hold(1);
        clr_flags = 3'b000;
    endtask

    // Monitor: scoreboard pop on every delivered byte, status pulse tracking
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_rx) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected irq_rx", {24'd0, rx_data}, 32'hFFFF);
                end else begin
                    chk("R6 rx_data", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
                end
            end
            if (irq_stat) begin
                stat_cnt++;
                if (prev_stat) chk("R1 irq_stat width", 32'd2, 32'd1);
            end
            prev_stat <= irq_stat;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int s0;
        hold(5);
        rst_n = 1'b1;
        hold(2);
        // R10 reset state
        chk("R10 reset brk_ok", brk_ok, 0);
        chk("R10 reset fe", fe_flag, 0);
        chk("R10 reset ove", ove_flag, 0);
        chk("R10 reset rx_data", rx_data, 0);
        chk("R11 reset busy", brk_busy, 0);

        // R4: arm ignored while disabled
        pulse_arm();
        hold(1);
        chk("R4 arm while disabled", brk_busy, 0);

        rx_en = 1'b1;
        hold(2);
        pulse_arm();
        chk("R4 arm sets busy", brk_busy, 1);

        // R5: traffic during break wait is suppressed
        send_byte(8'hA5, 1'b1);
        send_byte(8'h00, 1'b0);
        chk("R5 rx_data held", rx_data, 0);
        chk("R5 fe suppressed", fe_flag, 0);
        chk("R5 ove suppressed", ove_flag, 0);

        // R3: 175-tick low is a break error
        s0 = stat_cnt;
        line_low(175);
        chk("R3 busy stays", brk_busy, 1);
        chk("R3 no brk_ok", brk_ok, 0);
        chk("R3 no irq_stat", stat_cnt - s0, 0);

        // R1: exactly 176 ticks is valid
        line_low(176);
        chk("R1 brk_ok", brk_ok, 1);
        chk("R1 busy cleared", brk_busy, 0);
        chk("R1 one irq_stat", stat_cnt - s0, 1);

        // R6: normal bytes
        exp_q.push_back(8'h3C);
        send_byte(8'h3C, 1'b1);
        pulse_read();
        exp_q.push_back(8'h81);
        send_byte(8'h81, 1'b1);
        pulse_read();
        chk("R6 no overrun when read", ove_flag, 0);
        chk("R7 no fe on good stop", fe_flag, 0);

        // R8: overrun
        exp_q.push_back(8'h5A);
        send_byte(8'h5A, 1'b1);
        exp_q.push_back(8'h0F);
        send_byte(8'h0F, 1'b1);
        chk("R8 overrun set", ove_flag, 1);
        pulse_read();

        // R7: framing error
        exp_q.push_back(8'h55);
        send_byte(8'h55, 1'b0);
        chk("R7 fe set", fe_flag, 1);
        chk("R7 byte delivered", rx_data, 8'h55);
        pulse_read();

        // R10: write-one-to-clear
        clear(3'b010);
        chk("R10 fe cleared", fe_flag, 0);
        chk("R10 ove kept", ove_flag, 1);
        clear(3'b101);
        chk("R10 ove cleared", ove_flag, 0);
        chk("R10 brk_ok cleared", brk_ok, 0);

        // R2: nominal 13-bit break
        pulse_arm();
        s0 = stat_cnt;
        line_low(208);
        chk("R2 13-bit break ok", brk_ok, 1);
        chk("R2 busy cleared", brk_busy, 0);
        chk("R2 one irq_stat", stat_cnt - s0, 1);
        exp_q.push_back(8'hC3);
        send_byte(8'hC3, 1'b1);
        pulse_read();

        // R9: auto re-arm in mode 2'b10
        clear(3'b111);
        mode = 2'b10;
        s0 = stat_cnt;
        rxd = 1'b0;
        hold(190);
        chk("R9 auto busy", brk_busy, 1);
        hold(18);
        rxd = 1'b1;
        hold(40);
        chk("R9 auto break ok", brk_ok, 1);
        chk("R9 busy cleared", brk_busy, 0);
        chk("R9 no fe", fe_flag, 0);
        chk("R9 one irq_stat", stat_cnt - s0, 1);

        // R9 contrast: other mode delivers 0x00 with framing error
        clear(3'b111);
        mode = 2'b00;
        exp_q.push_back(8'h00);
        line_low(208);
        chk("R9 mode00 no busy", brk_busy, 0);
        chk("R9 mode00 fe", fe_flag, 1);
        chk("R9 mode00 no brk_ok", brk_ok, 0);
        pulse_read();

        // R11: disabled receiver
        rx_en = 1'b0;
        hold(2);
        chk("R11 busy low", brk_busy, 0);
        send_byte(8'h99, 1'b1);
        chk("R11 data unchanged", rx_data, 8'h00);

        hold(10);
        chk("R6 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule